// File: doc/BRIEF.md
# Logical AND execution unit

This unit executes three AND-based instructions for a small CPU core with 8-bit registers and 16-bit index registers. The register form ANDs a source register with the active accumulator and writes the result to a destination register. The indexed form computes the same AND and stores the result to data memory. The memory address comes from one of four index registers, and that register can be incremented or decremented before or after the access. The bit-test form ANDs one of the registers R0 to R15 with an 8-bit immediate and keeps only the flags.

The core presents a 16-bit instruction word together with a one-cycle issue strobe while the unit is idle. The unit reads its operands through combinational read ports at the issue cycle: the register file, the index-register file, and both accumulators. The bank select picks which accumulator is used. All writes leave the unit as single-cycle strobes on separate register, index-register and data-memory write ports. The N and Z flags are held in the unit.

Top module: `logic_and_unit`

## Requirements
- R1: Register form, encoded as instr[15:10]=100100, Rd in instr[9:5] and Rs in instr[4:0]. In the cycle after issue, the unit pulses rd_we_o for exactly one cycle with rd_addr_o=Rd and rd_wdata_o = Rs AND accumulator, and asserts done_o in that same cycle.
- R2: The accumulator operand is acc_main_i when bank_alt_i is 0 and acc_alt_i when it is 1, sampled in the issue cycle.
- R3: Indexed form, encoded as instr[15:9]=1001010, mode in instr[8:7], index select in instr[6:5] and Rs in instr[4:0]. In the third cycle (two cycles after issue), the unit pulses mem_we_o with mem_wdata_o = Rs AND accumulator and asserts done_o.
- R4: The mode field sets the memory address and the new index value. 00 uses the old value as the address and then decrements. 01 uses the old value and leaves it unchanged. 10 uses the old value and then increments. 11 increments first and uses the new value as the address. Arithmetic wraps at 16 bits.
- R5: An index select of 00, 01, 10 or 11 chooses index register 0, 1, 2 or 3. The selection appears on ix_sel_o at issue and on ix_wsel_o at write-back.
- R6: In the cycle after an indexed issue, ix_we_o pulses with the updated value on ix_wdata_o when the mode is not 01. It stays low for mode 01.
- R7: Bit test, encoded as instr[15:12]=0110, immediate in instr[11:4] and register in instr[3:0], reads registers R0 to R15 only. It completes in the cycle after issue with done_o and writes no register, index register or memory.
- R8: At the end of each instruction, flag_n_o takes the result MSB and flag_z_o is set exactly when the result is zero. Otherwise both flags hold their values.
- R9: issue_i is ignored while busy_o is high. busy_o is high for 1 cycle after a register-form or bit-test issue and for 2 cycles after an indexed issue.
- R10: An instruction word matching none of the three encodings is ignored. busy_o stays low, no write strobe occurs and the flags are unchanged.
- R11: After reset, busy_o, done_o, all write strobes and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction valid strobe |
| instr_i | input | 16 | Instruction word |
| bank_alt_i | input | 1 | Accumulator bank select (1 = alternate) |
| acc_main_i | input | DATA_W | Main-bank accumulator value |
| acc_alt_i | input | DATA_W | Alternate-bank accumulator value |
| rs_addr_o | output | 5 | Source register read address |
| rs_data_i | input | DATA_W | Source register read data |
| ix_sel_o | output | 2 | Index register read select |
| ix_data_i | input | ADDR_W | Index register read data |
| ix_we_o | output | 1 | Index register write strobe |
| ix_wsel_o | output | 2 | Index register write select |
| ix_wdata_o | output | ADDR_W | Updated index value |
| rd_we_o | output | 1 | Destination register write strobe |
| rd_addr_o | output | 5 | Destination register address |
| rd_wdata_o | output | DATA_W | Destination register write data |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_addr_o | output | ADDR_W | Data memory address |
| mem_wdata_o | output | DATA_W | Data memory write data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Last cycle of an instruction |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
The bench builds the unit with DATA_W=8 and ADDR_W=16, the widths the instruction format implies. At these widths it can sweep every source register and every destination pairing in both banks. It runs all sixteen combinations of index select and mode, with index values at 0x0000 and 0xFFFF so that increment and decrement wrap. It also tests every bit-test register against immediates chosen to give zero, negative and single-bit results. Issue attempts during an indexed instruction, and an undefined opcode, are checked at the write strobes and the flags.

// File: rtl/lau_pkg.sv
package lau_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 8;

  localparam logic [5:0] OPC_AND_REG  = 6'b100100;
  localparam logic [6:0] OPC_AND_IDX  = 7'b1001010;
  localparam logic [3:0] OPC_BIT_TEST = 4'b0110;

  localparam logic [1:0] MODE_POST_DEC = 2'b00;
  localparam logic [1:0] MODE_KEEP     = 2'b01;
  localparam logic [1:0] MODE_POST_INC = 2'b10;
  localparam logic [1:0] MODE_PRE_INC  = 2'b11;

  typedef enum logic [1:0] {OP_NONE, OP_AND_REG, OP_AND_IDX, OP_BIT_TEST} lau_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_T2, ST_T3} lau_state_e;

  typedef struct packed {
    lau_op_e            op;
    logic [REG_AW-1:0]  rs;
    logic [REG_AW-1:0]  rd;
    logic [1:0]         mode;
    logic [1:0]         ix_sel;
    logic [IMM_W-1:0]   imm;
  } lau_dec_t;
endpackage

// File: rtl/lau_decode.sv
module lau_decode
  import lau_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output lau_dec_t           dec_o
);
  logic is_reg, is_idx, is_bit;

  assign is_reg = (instr_i[15:10] == OPC_AND_REG);
  assign is_idx = (instr_i[15:9]  == OPC_AND_IDX);
  assign is_bit = (instr_i[15:12] == OPC_BIT_TEST);

  always_comb begin
    dec_o        = '0;
    dec_o.rd     = instr_i[9:5];
    dec_o.mode   = instr_i[8:7];
    dec_o.ix_sel = instr_i[6:5];
    dec_o.imm    = instr_i[11:4];
    dec_o.rs     = instr_i[4:0];
    if (is_reg) begin
      dec_o.op = OP_AND_REG;
    end else if (is_idx) begin
      dec_o.op = OP_AND_IDX;
    end else if (is_bit) begin
      dec_o.op = OP_BIT_TEST;
      dec_o.rs = {1'b0, instr_i[3:0]};
    end else begin
      dec_o.op = OP_NONE;
    end
  end

  always_comb begin
    AST_DECODE_EXCLUSIVE: assert ($countones({is_reg, is_idx, is_bit}) <= 1)
      else $error("opcode patterns overlap"); // R10
  end
endmodule

// File: rtl/lau_idx_unit.sv
module lau_idx_unit
  import lau_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] ix_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] next_o,
  output logic              wr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] step(input logic [1:0] m, input logic [ADDR_W-1:0] v);
    case (m)
      MODE_POST_DEC: step = v - ONE;
      MODE_KEEP:     step = v;
      default:       step = v + ONE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] eff_addr(input logic [1:0] m, input logic [ADDR_W-1:0] v);
    eff_addr = (m == MODE_PRE_INC) ? v + ONE : v;
  endfunction

  assign next_o = step(mode_i, ix_i);
  assign addr_o = eff_addr(mode_i, ix_i);
  assign wr_o   = (mode_i != MODE_KEEP);

  always_comb begin
    AST_PRE_INC_ADDR: assert (mode_i != MODE_PRE_INC || addr_o == next_o)
      else $error("pre-increment address differs from new index"); // R4
    AST_KEEP_NO_WRITE: assert (mode_i != MODE_KEEP || (!wr_o && next_o == ix_i))
      else $error("keep mode changes index"); // R6
  end
endmodule

// File: rtl/lau_flags.sv
module lau_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              n_o,
  output logic              z_o
);
  function automatic logic sign_of(input logic [DATA_W-1:0] v);
    sign_of = v[DATA_W-1];
  endfunction

  function automatic logic zero_of(input logic [DATA_W-1:0] v);
    zero_of = (v == '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_o <= 1'b0;
      z_o <= 1'b0;
    end else if (upd_i) begin
      n_o <= sign_of(result_i);
      z_o <= zero_of(result_i);
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> ($stable(n_o) && $stable(z_o))) else $error("flags moved without update"); // R8
endmodule

// File: rtl/logic_and_unit.sv
module logic_and_unit
  import lau_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [15:0]       instr_i,
  input  logic              bank_alt_i,
  input  logic [DATA_W-1:0] acc_main_i,
  input  logic [DATA_W-1:0] acc_alt_i,
  output logic [4:0]        rs_addr_o,
  input  logic [DATA_W-1:0] rs_data_i,
  output logic [1:0]        ix_sel_o,
  input  logic [ADDR_W-1:0] ix_data_i,
  output logic              ix_we_o,
  output logic [1:0]        ix_wsel_o,
  output logic [ADDR_W-1:0] ix_wdata_o,
  output logic              rd_we_o,
  output logic [4:0]        rd_addr_o,
  output logic [DATA_W-1:0] rd_wdata_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);
  lau_dec_t          dec;
  lau_state_e        state_q, state_d;
  lau_op_e           op_q;
  logic [REG_AW-1:0] rd_q;
  logic [1:0]        mode_q, sel_q;
  logic [DATA_W-1:0] opa_q, opb_q, opb_d, result;
  logic [ADDR_W-1:0] ix_q, idx_addr, idx_next;
  logic              idx_wr, accept, flag_upd;

  function automatic logic [DATA_W-1:0] and_op(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    and_op = a & b;
  endfunction

  lau_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  assign rs_addr_o = dec.rs;
  assign ix_sel_o  = dec.ix_sel;
  assign accept    = issue_i && (state_q == ST_IDLE) && (dec.op != OP_NONE);

  always_comb begin
    if (dec.op == OP_BIT_TEST) opb_d = DATA_W'(dec.imm);
    else if (bank_alt_i)       opb_d = acc_alt_i;
    else                       opb_d = acc_main_i;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_T2;
      ST_T2:   state_d = (op_q == OP_AND_IDX) ? ST_T3 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      rd_q    <= '0;
      mode_q  <= '0;
      sel_q   <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      ix_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= dec.op;
        rd_q   <= dec.rd;
        mode_q <= dec.mode;
        sel_q  <= dec.ix_sel;
        opa_q  <= rs_data_i;
        opb_q  <= opb_d;
        ix_q   <= ix_data_i;
      end
    end
  end

  lau_idx_unit #(.ADDR_W(ADDR_W)) u_idx (
    .mode_i(mode_q), .ix_i(ix_q), .addr_o(idx_addr), .next_o(idx_next), .wr_o(idx_wr)
  );

  assign result      = and_op(opa_q, opb_q);
  assign busy_o      = (state_q != ST_IDLE);
  assign rd_we_o     = (state_q == ST_T2) && (op_q == OP_AND_REG);
  assign rd_addr_o   = rd_q;
  assign rd_wdata_o  = result;
  assign ix_we_o     = (state_q == ST_T2) && (op_q == OP_AND_IDX) && idx_wr;
  assign ix_wsel_o   = sel_q;
  assign ix_wdata_o  = idx_next;
  assign mem_we_o    = (state_q == ST_T3);
  assign mem_addr_o  = idx_addr;
  assign mem_wdata_o = result;
  assign done_o      = ((state_q == ST_T2) && (op_q != OP_AND_IDX)) || (state_q == ST_T3);
  assign flag_upd    = done_o;

  lau_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd_i(flag_upd), .result_i(result), .n_o(flag_n_o), .z_o(flag_z_o)
  );

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we_o || mem_we_o || ix_we_o) |-> busy_o) else $error("write strobe while idle"); // R1
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_we_o, mem_we_o, ix_we_o})) else $error("several write strobes at once"); // R7
  AST_MEM_AFTER_T2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(busy_o && !done_o)) else $error("memory write not in third cycle"); // R3
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o) else $error("busy after done"); // R9
  AST_IGNORE_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && issue_i && dec.op == OP_NONE) |=> !busy_o) else $error("undefined opcode started"); // R10
endmodule

// File: tb/logic_and_unit_test.sv
`timescale 1ns/1ps
module logic_and_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        bank_alt_i = 1'b0;
  logic [7:0]  acc_main_i = '0, acc_alt_i = '0;
  logic [4:0]  rs_addr_o, rd_addr_o;
  logic [7:0]  rs_data_i, rd_wdata_o, mem_wdata_o;
  logic [1:0]  ix_sel_o, ix_wsel_o;
  logic [15:0] ix_data_i, ix_wdata_o, mem_addr_o;
  logic        ix_we_o, rd_we_o, mem_we_o, busy_o, done_o, flag_n_o, flag_z_o;

  logic [7:0]  regs [32];
  logic [15:0] ixr [4];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rs_data_i = regs[rs_addr_o];
  assign ix_data_i = ixr[ix_sel_o];

  logic_and_unit #(.DATA_W(8), .ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i), .bank_alt_i(bank_alt_i),
    .acc_main_i(acc_main_i), .acc_alt_i(acc_alt_i), .rs_addr_o(rs_addr_o), .rs_data_i(rs_data_i),
    .ix_sel_o(ix_sel_o), .ix_data_i(ix_data_i), .ix_we_o(ix_we_o), .ix_wsel_o(ix_wsel_o),
    .ix_wdata_o(ix_wdata_o), .rd_we_o(rd_we_o), .rd_addr_o(rd_addr_o), .rd_wdata_o(rd_wdata_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .busy_o(busy_o),
    .done_o(done_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_reg(input int rs, input int rd);
    return {6'b100100, rd[4:0], rs[4:0]};
  endfunction
  function automatic logic [15:0] enc_idx(input int rs, input int sel, input int mode);
    return {7'b1001010, mode[1:0], sel[1:0], rs[4:0]};
  endfunction
  function automatic logic [15:0] enc_bit(input int r, input int imm);
    return {4'b0110, imm[7:0], r[3:0]};
  endfunction

  function automatic logic [7:0] active_acc();
    return bank_alt_i ? acc_alt_i : acc_main_i;
  endfunction

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    instr_i = w;
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  task automatic check_flags(input string req, input logic [7:0] exp);
    check(req, {31'd0, flag_n_o}, {31'd0, exp[7]});
    check(req, {31'd0, flag_z_o}, {31'd0, exp == 8'd0});
  endtask

  task automatic run_reg(input int rs, input int rd);
    logic [7:0] exp;
    exp = regs[rs] & active_acc();
    issue(enc_reg(rs, rd));
    check("R1 rd_we", {31'd0, rd_we_o}, 32'd1);
    check("R1 rd_addr", {27'd0, rd_addr_o}, rd);
    check("R2 rd_wdata", {24'd0, rd_wdata_o}, {24'd0, exp});
    check("R1 done", {31'd0, done_o}, 32'd1);
    check("R1 mem_we", {31'd0, mem_we_o}, 32'd0);
    @(negedge clk);
    check("R9 busy end", {31'd0, busy_o}, 32'd0);
    check("R1 rd_we one cycle", {31'd0, rd_we_o}, 32'd0);
    check_flags("R8 reg flags", exp);
  endtask

  task automatic run_idx(input int rs, input int sel, input int mode);
    logic [7:0]  exp;
    logic [15:0] ix, addr, nxt;
    exp = regs[rs] & active_acc();
    ix = ixr[sel];
    case (mode)
      0: begin addr = ix; nxt = ix - 16'd1; end
      1: begin addr = ix; nxt = ix; end
      2: begin addr = ix; nxt = ix + 16'd1; end
      default: begin nxt = ix + 16'd1; addr = nxt; end
    endcase
    issue(enc_idx(rs, sel, mode));
    instr_i = enc_reg(3, 7);
    issue_i = 1'b1;
    check("R6 ix_we", {31'd0, ix_we_o}, {31'd0, mode != 1});
    check("R5 ix_wsel", {30'd0, ix_wsel_o}, sel);
    if (mode != 1) check("R4 ix_wdata", {16'd0, ix_wdata_o}, {16'd0, nxt});
    check("R3 no early mem", {31'd0, mem_we_o}, 32'd0);
    check("R3 no done T2", {31'd0, done_o}, 32'd0);
    @(negedge clk);
    check("R3 mem_we", {31'd0, mem_we_o}, 32'd1);
    check("R4 mem_addr", {16'd0, mem_addr_o}, {16'd0, addr});
    check("R3 mem_wdata", {24'd0, mem_wdata_o}, {24'd0, exp});
    check("R3 done", {31'd0, done_o}, 32'd1);
    check("R9 no rd_we while busy", {31'd0, rd_we_o}, 32'd0);
    @(negedge clk);
    issue_i = 1'b0;
    check("R9 issue ignored busy", {31'd0, busy_o}, 32'd0);
    check("R9 issue ignored rd", {31'd0, rd_we_o}, 32'd0);
    check_flags("R8 idx flags", exp);
  endtask

  task automatic run_bit(input int r, input int imm);
    logic [7:0] exp;
    exp = regs[r] & imm[7:0];
    issue(enc_bit(r, imm));
    check("R7 done", {31'd0, done_o}, 32'd1);
    check("R7 no writes", {29'd0, rd_we_o, mem_we_o, ix_we_o}, 32'd0);
    @(negedge clk);
    check("R7 busy end", {31'd0, busy_o}, 32'd0);
    check_flags("R8 bit flags", exp);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 8'(i * 37 + 5);
    regs[0] = 8'h00;
    regs[9] = 8'hFF;
    ixr[0] = 16'h0000; ixr[1] = 16'hFFFF; ixr[2] = 16'h1234; ixr[3] = 16'h8000;
    #1;
    check("R11 busy", {31'd0, busy_o}, 32'd0);
    check("R11 strobes", {28'd0, rd_we_o, mem_we_o, ix_we_o, done_o}, 32'd0);
    check("R11 flags", {30'd0, flag_n_o, flag_z_o}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) begin
      for (int b = 0; b < 2; b++) begin
        bank_alt_i = b[0];
        acc_main_i = 8'(i * 13);
        acc_alt_i  = ~8'(i * 7);
        run_reg(i, 31 - i);
      end
    end
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int b = 0; b < 2; b++) begin
          bank_alt_i = b[0];
          acc_main_i = 8'h8F;
          acc_alt_i  = 8'h3C;
          run_idx(s * 8 + m * 2 + b, s, m);
        end
      end
    end
    for (int r = 0; r < 16; r++) begin
      run_bit(r, 0);
      run_bit(r, 8'h80);
      run_bit(r, 8'hFF);
      run_bit(r, 8'h01);
      run_bit(r, r * 17);
    end
    acc_main_i = 8'hF0; bank_alt_i = 1'b0;
    run_reg(9, 4);
    issue(16'h0000);
    check("R10 undef busy", {31'd0, busy_o}, 32'd0);
    check("R10 undef writes", {28'd0, rd_we_o, mem_we_o, ix_we_o, done_o}, 32'd0);
    check("R10 undef flags", {30'd0, flag_n_o, flag_z_o}, 32'd2);
    issue(16'hFFFF);
    check("R10 undef busy 2", {31'd0, busy_o}, 32'd0);
    check("R10 undef flags 2", {30'd0, flag_n_o, flag_z_o}, 32'd2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule